// File: doc/BRIEF.md
# Eight-Bit Execute Unit with Condition Flags

This block computes the register-to-register and immediate operations of a small eight-bit processor. Each accepted operation takes a source (or modifier) operand, a destination operand, a four-bit operation code and the current condition flags. The three flags are carry, zero and sign. The block returns the new destination value, a write enable for the destination register, and the next flag values. Immediate forms need no special handling here: the operand fetch logic outside the block places the immediate byte on the source input.

The operations fall into five groups:
- arithmetic: add, add with carry, subtract, subtract with borrow, and a compare that changes only the flags;
- bitwise logic: and, or, exclusive or;
- plain move;
- one-bit shifts, and rotates that pass through the carry;
- increment and decrement, plus an exchange that swaps the accumulator value with the packed flag bits.

Register storage and operand selection are outside this block. The result is registered: an operation presented with `in_valid` in one cycle appears on the outputs after the next rising clock edge.

Top module: `alu8_exec`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `out_valid`, `wr_en`, `result` and `flags_out` all read 0.
- R2: An operation accepted with `in_valid` high at a rising edge is reported with `out_valid` high right after that edge. A cycle without `in_valid` gives `out_valid` and `wr_en` low after the next edge. `wr_en` is never high while `out_valid` is low.
- R3: Addition adds the destination and source operands: code 0 adds them alone, and code 1 also adds the incoming carry. The new carry is the carry out of bit 7, and the result is written.
- R4: Subtraction computes destination minus source: code 2 subtracts the source alone, and code 3 also subtracts the incoming carry. The new carry is 1 exactly when a borrow occurs, and the result is written.
- R5: Compare (code 4) produces the flags and result value of code 2, but `wr_en` stays low.
- R6: Codes 5, 6 and 7 give the bitwise and, or and exclusive or of the two operands. The result is written and the carry keeps its incoming value.
- R7: Move (code 8) writes the source operand as the result and passes all three incoming flags through unchanged.
- R8: Code 9 shifts the destination right by one bit with 0 entering bit 7. Code 10 shifts it left by one bit with 0 entering bit 0. In both cases the bit shifted out becomes the new carry.
- R9: Code 11 shifts right with the incoming carry entering bit 7. Code 12 shifts left with the incoming carry entering bit 0. In both cases the bit shifted out becomes the new carry.
- R10: Code 13 adds 1 to the destination and code 14 subtracts 1 from it, both wrapping modulo 256. The carry keeps its incoming value.
- R11: Exchange (code 15) takes the accumulator value on the destination input. It writes the packed incoming flags as the result (bits 7..3 zero). The new flags are taken from bits 2..0 of the destination input.
- R12: The flag ports pack carry in bit 0, zero in bit 1 and sign in bit 2. For every code other than 8 and 15, the new zero flag is 1 exactly when the 8-bit result is 0, and the new sign flag equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| src_opnd | input | 8 | Source or modifier operand, or the immediate byte |
| dst_opnd | input | 8 | Current destination value; the accumulator value for the exchange |
| flags_in | input | 3 | Current flags: bit 0 carry, bit 1 zero, bit 2 sign |
| out_valid | output | 1 | Registered result is valid |
| result | output | 8 | Registered result value |
| wr_en | output | 1 | Destination register should be written |
| flags_out | output | 3 | Next flags, same packing as `flags_in` |

## Verification
The assertions assume that `flags_in` and the operands are stable and known whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first operation. The stimulus drives every input on the falling edge, holds it through the following rising edge, and keeps `in_valid` low during reset and between scenarios. The exchange and the move are the only operations whose flags do not follow the result, so the flag assertions exclude those two codes, and the stimulus covers them with their own scenarios.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 3;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_MOV = 4'd8,
        OP_SHR = 4'd9,
        OP_SHL = 4'd10,
        OP_RCR = 4'd11,
        OP_RCL = 4'd12,
        OP_INC = 4'd13,
        OP_DEC = 4'd14,
        OP_SWP = 4'd15
    } alu_op_e;

    // bit 0 carry, bit 1 zero, bit 2 sign
    typedef struct packed {
        logic s;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o    = wide_sum[W-1:0];
        // subtraction runs as a + ~b + ~borrow_in; borrow is the missing carry
        carry_o  = sub_i ? ~wide_sum[W] : wide_sum[W];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    // sel: 0 and, 1 or, 2 xor
    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  logic         left_i,
    input  logic         thru_c_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic fill;

    always_comb begin
        fill = thru_c_i & cin_i;
        if (left_i) begin
            res_o  = {val_i[W-2:0], fill};
            cout_o = val_i[W-1];
        end else begin
            res_o  = {fill, val_i[W-1:1]};
            cout_o = val_i[0];
        end
    end
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] src_opnd,
    input  logic [W-1:0] dst_opnd,
    input  logic [2:0]   flags_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [2:0]   flags_out
);
    import alu8_pkg::*;

    localparam int PAD_W = W - FLAG_W;

    typedef struct packed {
        logic         vld;
        logic         we;
        logic [W-1:0] res;
        flags_t       flg;
        alu_op_e      op;
    } stage_t;

    stage_t  cur_q, nxt_d;
    alu_op_e op_i;
    flags_t  fin;

    assign op_i = alu_op_e'(op);
    assign fin  = flags_t'(flags_in);

    // adder operand steering
    logic [W-1:0] add_b;
    logic         add_cin, add_sub;
    logic [W-1:0] add_sum;
    logic         add_c;

    always_comb begin
        add_b   = src_opnd;
        add_cin = 1'b0;
        add_sub = 1'b0;
        unique case (op_i)
            OP_ADC: add_cin = fin.c;
            OP_SUB, OP_CMP: begin
                add_b   = ~src_opnd;
                add_cin = 1'b1;
                add_sub = 1'b1;
            end
            OP_SBC: begin
                add_b   = ~src_opnd;
                add_cin = ~fin.c;
                add_sub = 1'b1;
            end
            OP_INC: begin
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC:  add_b = '1;
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i     (dst_opnd),
        .b_i     (add_b),
        .cin_i   (add_cin),
        .sub_i   (add_sub),
        .sum_o   (add_sum),
        .carry_o (add_c)
    );

    logic [W-1:0] log_res;
    logic [1:0]   log_sel;

    assign log_sel = (op_i == OP_AND) ? 2'd0 : (op_i == OP_OR) ? 2'd1 : 2'd2;

    alu8_logic #(.W(W)) u_logic (
        .a_i   (dst_opnd),
        .b_i   (src_opnd),
        .sel_i (log_sel),
        .res_o (log_res)
    );

    logic [W-1:0] sh_res;
    logic         sh_c;
    logic         sh_left, sh_thru;

    assign sh_left = (op_i == OP_SHL) || (op_i == OP_RCL);
    assign sh_thru = (op_i == OP_RCR) || (op_i == OP_RCL);

    alu8_shift #(.W(W)) u_shift (
        .val_i    (dst_opnd),
        .cin_i    (fin.c),
        .left_i   (sh_left),
        .thru_c_i (sh_thru),
        .res_o    (sh_res),
        .cout_o   (sh_c)
    );

    always_comb begin
        logic [W-1:0] r;
        logic         c_new;
        nxt_d     = cur_q;
        nxt_d.vld = in_valid;
        nxt_d.we  = 1'b0;
        r         = add_sum;
        c_new     = fin.c;
        if (in_valid) begin
            nxt_d.op = op_i;
            nxt_d.we = (op_i != OP_CMP);
            unique case (op_i)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                    r     = add_sum;
                    c_new = add_c;
                end
                OP_INC, OP_DEC: r = add_sum;
                OP_AND, OP_OR, OP_XOR: r = log_res;
                OP_SHR, OP_SHL, OP_RCR, OP_RCL: begin
                    r     = sh_res;
                    c_new = sh_c;
                end
                default: r = src_opnd;
            endcase
            nxt_d.res = r;
            nxt_d.flg = '{s: r[W-1], z: (r == '0), c: c_new};
            if (op_i == OP_MOV) begin
                nxt_d.flg = fin;
            end else if (op_i == OP_SWP) begin
                nxt_d.res = {{PAD_W{1'b0}}, fin};
                nxt_d.flg = flags_t'(dst_opnd[FLAG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{vld: 1'b0, we: 1'b0, res: '0, flg: '0, op: OP_ADD};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_valid = cur_q.vld;
    assign wr_en     = cur_q.we;
    assign result    = cur_q.res;
    assign flags_out = cur_q.flg;

    assert_wr_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_CMP) |=> !wr_en);

    assert_mov_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_MOV) |=> (flags_out == $past(flags_in)));

    assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR ||
                      op_i == OP_INC || op_i == OP_DEC))
        |=> (flags_out[0] == $past(flags_in[0])));

    assert_zero_sign_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cur_q.op != OP_MOV && cur_q.op != OP_SWP)
        |-> (flags_out[1] == (result == '0) && flags_out[2] == result[W-1]));

    assert_swap_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_SWP) |=> (result[W-1:FLAG_W] == '0));
endmodule

// File: tb/alu8_exec_tb.sv
`timescale 1ns/1ps
module alu8_exec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] src_opnd = 8'd0;
    logic [7:0] dst_opnd = 8'd0;
    logic [2:0] flags_in = 3'd0;
    logic       out_valid;
    logic [7:0] result;
    logic       wr_en;
    logic [2:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_exec u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .src_opnd  (src_opnd),
        .dst_opnd  (dst_opnd),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .wr_en     (wr_en),
        .flags_out (flags_out)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive on falling edge, result visible after next rising edge, sample at next falling edge
    task automatic run_op(string req, logic [3:0] c, logic [7:0] s, logic [7:0] d,
                          logic [2:0] f, logic [7:0] eres, logic ewe, logic [2:0] eflg);
        @(negedge clk);
        in_valid = 1'b1; op = c; src_opnd = s; dst_opnd = d; flags_in = f;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "out_valid", {7'd0, out_valid}, 8'd1);
        check(req, "result", result, eres);
        check(req, "wr_en", {7'd0, wr_en}, {7'd0, ewe});
        check(req, "flags", {5'd0, flags_out}, {5'd0, eflg});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "out_valid", {7'd0, out_valid}, 8'd0);
        check("R1", "wr_en", {7'd0, wr_en}, 8'd0);
        check("R1", "result", result, 8'd0);
        check("R1", "flags", {5'd0, flags_out}, 8'd0);
    endtask

    task automatic t_idle;
        run_op("R2", 4'd0, 8'h01, 8'h01, 3'b000, 8'h02, 1'b1, 3'b000);
        @(negedge clk);
        check("R2", "idle out_valid", {7'd0, out_valid}, 8'd0);
        check("R2", "idle wr_en", {7'd0, wr_en}, 8'd0);
    endtask

    task automatic t_add;
        run_op("R3", 4'd0, 8'h01, 8'h7F, 3'b000, 8'h80, 1'b1, 3'b100);
        run_op("R3", 4'd0, 8'h01, 8'hFF, 3'b000, 8'h00, 1'b1, 3'b011);
        run_op("R3", 4'd1, 8'h20, 8'h10, 3'b001, 8'h31, 1'b1, 3'b000);
    endtask

    task automatic t_sub;
        run_op("R4", 4'd2, 8'h07, 8'h05, 3'b000, 8'hFE, 1'b1, 3'b101);
        run_op("R4", 4'd3, 8'h05, 8'h05, 3'b001, 8'hFF, 1'b1, 3'b101);
        run_op("R4", 4'd3, 8'h03, 8'h08, 3'b000, 8'h05, 1'b1, 3'b000);
    endtask

    task automatic t_cmp;
        run_op("R5", 4'd4, 8'h42, 8'h42, 3'b000, 8'h00, 1'b0, 3'b010);
        run_op("R5", 4'd4, 8'h43, 8'h42, 3'b010, 8'hFF, 1'b0, 3'b101);
    endtask

    task automatic t_logic;
        run_op("R6", 4'd5, 8'h0F, 8'hF0, 3'b001, 8'h00, 1'b1, 3'b011);
        run_op("R6", 4'd6, 8'h01, 8'h80, 3'b000, 8'h81, 1'b1, 3'b100);
        run_op("R6", 4'd7, 8'hAA, 8'hAA, 3'b001, 8'h00, 1'b1, 3'b011);
    endtask

    task automatic t_mov;
        run_op("R7", 4'd8, 8'h3C, 8'h00, 3'b101, 8'h3C, 1'b1, 3'b101);
        run_op("R7", 4'd8, 8'h00, 8'h55, 3'b000, 8'h00, 1'b1, 3'b000);
    endtask

    task automatic t_shift;
        run_op("R8", 4'd9,  8'h00, 8'h81, 3'b000, 8'h40, 1'b1, 3'b001);
        run_op("R8", 4'd10, 8'h00, 8'h81, 3'b000, 8'h02, 1'b1, 3'b001);
        run_op("R8", 4'd10, 8'h00, 8'h80, 3'b000, 8'h00, 1'b1, 3'b011);
        run_op("R8", 4'd9,  8'h00, 8'h80, 3'b001, 8'h40, 1'b1, 3'b000);
    endtask

    task automatic t_rotate;
        run_op("R9", 4'd11, 8'h00, 8'h02, 3'b001, 8'h81, 1'b1, 3'b100);
        run_op("R9", 4'd12, 8'h00, 8'h80, 3'b001, 8'h01, 1'b1, 3'b001);
        run_op("R9", 4'd12, 8'h00, 8'h40, 3'b000, 8'h80, 1'b1, 3'b100);
    endtask

    task automatic t_incdec;
        run_op("R10", 4'd13, 8'h00, 8'hFF, 3'b001, 8'h00, 1'b1, 3'b011);
        run_op("R10", 4'd14, 8'h00, 8'h00, 3'b000, 8'hFF, 1'b1, 3'b100);
        run_op("R10", 4'd14, 8'h00, 8'h01, 3'b001, 8'h00, 1'b1, 3'b011);
    endtask

    task automatic t_swap;
        run_op("R11", 4'd15, 8'h00, 8'h06, 3'b001, 8'h01, 1'b1, 3'b110);
        run_op("R11", 4'd15, 8'h00, 8'hF8, 3'b111, 8'h07, 1'b1, 3'b000);
    endtask

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_mov();
        t_shift();
        t_rotate();
        t_incdec();
        t_swap();
        t_idle();
        done = 1'b1;
        // R12 zero and sign flags are covered by the flag checks above
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule